// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block drives an 8-input, 12-bit successive-approximation converter over a four-wire serial link. It runs from the system clock. It makes the chip select and a divided serial clock, and it shifts a control byte out on the data-in line. That byte names the input the converter should sample next. Sixteen bits come back per conversion. The four leading zero bits are dropped and the 12-bit value goes out on a valid/ready stream, together with the channel it belongs to.

The converter works one frame behind: the address written during a frame sets the channel of the next frame's result. The controller therefore records the channel it asked for in each frame and attaches it to the result of the following frame. After reset it throws away the result of the first frame, because that conversion is of an unknown input. Enabled inputs are visited in ascending order and the order wraps around. While `run` is high and at least one input is enabled, frames follow each other back to back under a single chip-select window.

Top module: `adc_scan_ctrl`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `sclk` is 1, `din` is 0 and `m_valid` is 0.
- R2: `sclk` stays high whenever `cs_n` is high. When `cs_n` falls, `sclk` is high, and the first falling edge of `sclk` comes exactly `DIV` system clocks later. Every low phase of `sclk` lasts exactly `DIV` system clocks.
- R3: Each frame has exactly 16 rising edges of `sclk`. While scanning continues, `cs_n` stays low across frames, so each chip-select window holds a multiple of 16 rising edges.
- R4: `din` changes only on falling edges of `sclk`. On the first 8 rising edges of a frame it carries the control byte, MSB first. The requested channel number sits in bits 5:3 and all other bits are 0. On rising edges 9 to 16, `din` is 0.
- R5: `dout` is sampled on each rising edge of `sclk`. The first 4 bits of a frame are discarded. The last 12 bits form `m_data`, MSB first.
- R6: Requested channels are the enabled bits of `en_mask` (bit i enables input i) in ascending order, wrapping from the highest back to the lowest. The first request after reset is the lowest enabled channel.
- R7: The result of the first frame after reset is never presented on the output stream.
- R8: Every output sample has `m_chan` set to the channel requested in the frame before the one that produced it. Every non-dummy frame yields exactly one sample.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_data` and `m_chan` hold steady. No new frame starts, and `sclk` stays high.
- R10: When `run` is 0 or `en_mask` is all zero at a frame boundary, the current frame completes and then `cs_n` rises. With an all-zero mask, `cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Scanning allowed while high |
| en_mask | input | NCH | Per-input enable, bit i selects input i |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Control bits to the converter |
| dout | input | 1 | Result bits from the converter |
| m_valid | output | 1 | Output sample present |
| m_ready | input | 1 | Consumer accepts the sample |
| m_data | output | RES | 12-bit conversion result |
| m_chan | output | log2(NCH) | Input the result belongs to |

## Verification
The serial-side timing is checked to the exact system clock. The first `sclk` fall must come `DIV` clocks after `cs_n` falls, and each low phase is counted against `DIV` in the bench's negative-edge monitor. A sample is due `DIV` clocks after the 16th rising edge of its frame, plus one output register. The bench does not fix that cycle in advance: a behavioural converter model queues each expected result at the 16th rising edge, and the queue is compared at every handshake. Stall behaviour is checked one clock later: a cycle with `m_valid` high and `m_ready` low must be followed by the same data and no `sclk` fall.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CTRL_BITS  = 8;
  localparam int ADDR_LSB   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } scan_state_t;
endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  last,
  output logic [CW-1:0]  next,
  output logic           any
);
  // smallest forward distance from last wins; offset NCH allows reuse of last
  always_comb begin
    next = '0;
    for (int k = NCH; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NCH;
      if (mask[idx]) next = CW'(idx);
    end
  end

  assign any = |mask;
endmodule

// File: rtl/adc_scan_outreg.sv
module adc_scan_outreg #(
  parameter int RES = 12,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [RES-1:0] ld_data,
  input  logic [CW-1:0]  ld_chan,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [RES-1:0] m_data,
  output logic [CW-1:0]  m_chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_chan  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= ld_data;
      m_chan  <= ld_chan;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    load |-> !m_valid)
    else $error("sample loaded over a pending one");

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)))
    else $error("output changed during stall");
endmodule

// File: rtl/adc_scan_frame.sv
module adc_scan_frame
  import adc_scan_pkg::*;
#(
  parameter int DIV = 4,
  parameter int NCH = 8,
  parameter int RES = 12,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           slot_free,
  input  logic [CW-1:0]  req_chan,
  input  logic           dout,
  output logic           cs_n,
  output logic           sclk,
  output logic           din,
  output logic [CW-1:0]  last_req,
  output logic           ld,
  output logic [RES-1:0] ld_data,
  output logic [CW-1:0]  ld_chan
);
  localparam int FW   = FRAME_BITS;
  localparam int BW   = $clog2(FW);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;

  scan_state_t          state;
  logic [CNTW-1:0]      cnt;
  logic [BW-1:0]        bitn;
  logic [CTRL_BITS-1:0] ctrl;
  logic [FW-1:0]        shreg;
  logic [CW-1:0]        tag;
  logic                 dummy;

  logic                 cnt_end;
  logic                 start;
  logic [BW-1:0]        nb;
  logic                 din_nxt;
  logic [CTRL_BITS-1:0] ctrl_nxt;

  assign cnt_end = (cnt == CNTW'(DIV - 1));
  assign start   = go && slot_free;
  assign nb      = bitn + 1'b1;
  assign din_nxt = (nb < BW'(CTRL_BITS)) ? ctrl[3'd7 - nb[2:0]] : 1'b0;

  always_comb begin
    ctrl_nxt = '0;
    ctrl_nxt[ADDR_LSB +: CW] = req_chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      din      <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
      ctrl     <= '0;
      shreg    <= '0;
      last_req <= CW'(NCH - 1);
      tag      <= '0;
      dummy    <= 1'b1;
      ld       <= 1'b0;
      ld_data  <= '0;
      ld_chan  <= '0;
    end else begin
      ld <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cs_n     <= 1'b0;
          state    <= ST_SETUP;
          cnt      <= '0;
          ctrl     <= ctrl_nxt;
          tag      <= last_req;
          last_req <= req_chan;
        end
        ST_SETUP: if (cnt_end) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
          din   <= ctrl[CTRL_BITS-1];
          bitn  <= '0;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (cnt_end) begin
          state <= ST_HIGH;
          sclk  <= 1'b1;
          shreg <= {shreg[FW-2:0], dout};
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_HIGH: if (cnt_end) begin
          cnt <= '0;
          if (bitn == BW'(FW - 1)) begin
            state   <= ST_GAP;
            ld      <= !dummy;
            dummy   <= 1'b0;
            ld_data <= shreg[RES-1:0];
            ld_chan <= tag;
          end else begin
            state <= ST_LOW;
            sclk  <= 1'b0;
            bitn  <= nb;
            din   <= din_nxt;
          end
        end else cnt <= cnt + 1'b1;
        ST_GAP: if (start) begin
          state    <= ST_LOW;
          sclk     <= 1'b0;
          din      <= ctrl_nxt[CTRL_BITS-1];
          bitn     <= '0;
          cnt      <= '0;
          ctrl     <= ctrl_nxt;
          tag      <= last_req;
          last_req <= req_chan;
        end else if (!go) begin
          state <= ST_IDLE;
          cs_n  <= 1'b1;
          din   <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_sclk_high_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk)
    else $error("sclk low while deselected");

  p_cs_fall_sclk_high_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk)
    else $error("chip select fell with sclk low");

  p_din_tail_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && (state inside {ST_LOW, ST_HIGH}) && bitn >= BW'(CTRL_BITS)) |-> !din)
    else $error("din high after control byte");
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int DIV = 4,
  parameter int NCH = 8,
  parameter int RES = 12,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [NCH-1:0] en_mask,
  output logic           cs_n,
  output logic           sclk,
  output logic           din,
  input  logic           dout,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [RES-1:0] m_data,
  output logic [CW-1:0]  m_chan
);
  logic [CW-1:0]  req_chan;
  logic [CW-1:0]  last_req;
  logic           any_en;
  logic           ld;
  logic [RES-1:0] ld_data;
  logic [CW-1:0]  ld_chan;
  logic           slot_free;

  assign slot_free = !m_valid && !ld;

  adc_scan_pick #(.NCH(NCH), .CW(CW)) i_pick (
    .mask (en_mask),
    .last (last_req),
    .next (req_chan),
    .any  (any_en)
  );

  adc_scan_frame #(.DIV(DIV), .NCH(NCH), .RES(RES), .CW(CW)) i_frame (
    .clk       (clk),
    .rst       (rst),
    .go        (run && any_en),
    .slot_free (slot_free),
    .req_chan  (req_chan),
    .dout      (dout),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .last_req  (last_req),
    .ld        (ld),
    .ld_data   (ld_data),
    .ld_chan   (ld_chan)
  );

  adc_scan_outreg #(.RES(RES), .CW(CW)) i_out (
    .clk     (clk),
    .rst     (rst),
    .load    (ld),
    .ld_data (ld_data),
    .ld_chan (ld_chan),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_chan  (m_chan)
  );

  p_mask_zero_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (en_mask == '0 && cs_n) |=> cs_n)
    else $error("frame started with empty mask");
endmodule

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic [7:0]  en_mask;
  logic        cs_n, sclk, din;
  logic        dout;
  logic        m_valid, m_ready;
  logic [11:0] m_data;
  logic [2:0]  m_chan;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_scan_ctrl #(.DIV(DIV), .NCH(8), .RES(12)) i_adc_scan_ctrl (
    .clk(clk), .rst(rst), .run(run), .en_mask(en_mask),
    .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int next_en(input int last, input logic [7:0] m);
    for (int k = 1; k <= 8; k++) begin
      int i;
      i = (last + k) % 8;
      if (m[i]) return i;
    end
    return -1;
  endfunction

  // behavioural converter model
  int          rise_n = 0;
  int          fall_n = 0;
  logic [7:0]  ctl_sh = '0;
  int          adc_ch = 5;
  int          conv_no = 0;
  logic [11:0] cur_val = '0;
  logic [7:0]  mask_fr = '0;
  int          exp_last = 7;
  bit          first_conv = 1'b1;
  int          win_rises = 0;
  logic [14:0] expq[$];

  always @(negedge cs_n) begin
    rise_n = 0;
    fall_n = 0;
    mask_fr = en_mask;
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    int f;
    f = (fall_n % 16) + 1;
    if (f == 1) begin
      cur_val = {adc_ch[2:0], conv_no[8:0]};
      mask_fr = en_mask;
    end
    dout <= (f <= 4) ? 1'b0 : cur_val[16 - f];
    fall_n++;
  end

  always @(posedge sclk) if (cs_n === 1'b0) begin
    int r;
    r = (rise_n % 16) + 1;
    if (r <= 8) ctl_sh = {ctl_sh[6:0], din};
    else chk(din == 1'b0, "R4", "din after control byte", din, 0);
    if (r == 8) begin
      int e;
      e = next_en(exp_last, mask_fr);
      chk(ctl_sh == {2'b00, e[2:0], 3'b000}, "R6", "control byte", ctl_sh,
          {2'b00, e[2:0], 3'b000});
      exp_last = e;
    end
    if (r == 16) begin
      if (first_conv) first_conv = 1'b0;
      else expq.push_back({adc_ch[2:0], cur_val});
      adc_ch = int'(ctl_sh[5:3]);
      conv_no++;
    end
    rise_n++;
  end

  always @(posedge cs_n) if (rst === 1'b0) begin
    chk(rise_n > 0 && rise_n % 16 == 0, "R3", "rises per window", rise_n, 16);
    win_rises = rise_n;
  end

  // clock-by-clock monitor
  logic        p_v = 1'b0, p_r = 1'b1, p_s = 1'b1, p_cs = 1'b1;
  logic [11:0] p_d = '0;
  logic [2:0]  p_c = '0;
  int          lowlen = 0, sulen = 0, got = 0, first_chan = -1;
  bit          in_setup = 1'b0;

  always @(negedge clk) if (rst === 1'b0) begin
    chk(!cs_n || sclk, "R2", "sclk while deselected", sclk, 1);
    if (p_v && !p_r) begin
      chk(m_valid && m_data == p_d && m_chan == p_c, "R9", "stall hold",
          m_data, p_d);
      chk(!(p_s && !sclk), "R9", "sclk fell during stall", sclk, 1);
    end
    if (p_cs && !cs_n) begin
      in_setup = 1'b1;
      sulen = 1;
    end else if (in_setup && sclk) sulen++;
    else if (in_setup && !sclk) begin
      chk(sulen == DIV, "R2", "cs fall to first sclk fall", sulen, DIV);
      in_setup = 1'b0;
    end
    if (!sclk) lowlen++;
    else if (!p_s && !cs_n) begin
      chk(lowlen == DIV, "R2", "sclk low phase", lowlen, DIV);
      lowlen = 0;
    end else lowlen = 0;
    if (m_valid && m_ready) begin
      logic [14:0] e;
      if (first_chan < 0) first_chan = int'(m_chan);
      if (expq.size() == 0) chk(1'b0, "R8", "unexpected sample", m_data, -1);
      else begin
        e = expq.pop_front();
        chk(m_chan == e[14:12], "R8", "sample channel", m_chan, e[14:12]);
        chk(m_data == e[11:0], "R5", "sample data", m_data, e[11:0]);
      end
      got++;
    end
    p_v = m_valid; p_r = m_ready; p_s = sclk; p_cs = cs_n;
    p_d = m_data; p_c = m_chan;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; run = 1'b0; en_mask = '0; m_ready = 1'b1; dout = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
    chk(din == 1'b0, "R1", "din in reset", din, 0);
    chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
    rst = 1'b0;

    // wrap-around scan over inputs 0,2,5,7
    en_mask = 8'hA5; run = 1'b1;
    while (got < 10) @(negedge clk);
    chk(first_chan == 0, "R7", "first delivered channel", first_chan, 0);

    // stall
    m_ready = 1'b0;
    while (!m_valid) @(negedge clk);
    repeat (300) @(negedge clk);
    m_ready = 1'b1;
    while (got < 12) @(negedge clk);

    // stop
    run = 1'b0;
    while (!cs_n) @(negedge clk);
    chk(win_rises >= 16 * 12, "R3", "frames in one window", win_rises, 192);
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1, "R10", "cs_n after run low", cs_n, 1);

    // single input, tag carries request from before the stop
    en_mask = 8'h80; run = 1'b1;
    while (got < 16) @(negedge clk);
    run = 1'b0;
    while (!cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R8", "pending expected samples", expq.size(), 0);

    // empty mask holds chip select high
    en_mask = 8'h00; run = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!cs_n) chk(1'b0, "R10", "cs_n with empty mask", cs_n, 1);
    end
    chk(cs_n == 1'b1, "R10", "cs_n after empty-mask window", cs_n, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", got, 16);
    finish_run();
  end
endmodule